// File: doc/BRIEF.md
# Segment Access Checker

This block sits between an address generation stage and the memory pipeline of a segmented processor core. For each access it receives the cached fields of the selected segment: base, 20-bit limit, granularity flag, default-size flag and the access-rights byte. It also receives the 32-bit offset, the kind of access (read, write or instruction fetch), the access size, the current privilege level and the requested privilege level carried in the selector. From these it forms the linear address and decides whether the access may proceed.

All checks are combinational. Their results are captured in one output register, so the address, the fault flag and a 3-bit fault cause appear together one clock after the request. The limit check scales the limit by the granularity flag. It handles segments that grow upward and segments that grow downward. The type and privilege checks follow the meaning of the access-rights byte. When several faults apply at once, a fixed priority picks one cause.

Top module: `seg_access_check`

## Requirements
- R1: The outputs `out_valid`, `lin_addr`, `fault` and `fault_cause` update one clock after a request is presented. `out_valid` equals `req_valid` of the previous cycle. While `rst_n` is low, `out_valid` and `fault` are 0 and `fault_cause` is 0.
- R2: `lin_addr` is `seg_base + offset` modulo 2^32. It is produced even for faulting accesses.
- R3: The effective limit is `seg_limit` when `seg_gran` is 0. When `seg_gran` is 1 it is `(seg_limit << 12) | 0xFFF`.
- R4: `acc_size` holds the byte count minus one (0 to 3). The last byte is `offset + acc_size`. For code segments, and for data segments with rights bit 2 clear, the access is a limit fault when the last byte exceeds the effective limit.
- R5: A data segment with rights bit 2 set grows downward. Its valid offsets lie above the effective limit. The last byte may not exceed 0xFFFF when `seg_big` is 0, or 0xFFFFFFFF when `seg_big` is 1. Anything else is a limit fault.
- R6: Rights bit 7 clear means the segment is absent, which gives cause 1. This cause wins over every other cause.
- R7: Cause 3 (type) covers six cases. Rights bit 4 is clear (system descriptor). `acc_kind` is 3. A write to a code segment (bit 3 set). A fetch from a data segment. A write to a data segment whose bit 1 is clear. A read of a code segment whose bit 1 is clear. The access kinds are 0 read, 1 write, 2 fetch.
- R8: For reads and writes, the effective level is the numerically larger of `cpl` and `rpl`. The access is a privilege fault (cause 4) when this level is larger than the segment's DPL (rights bits 6:5). Reads of a conforming code segment (code with bit 2 set) skip this check.
- R9: A fetch from a non-conforming code segment needs `cpl` equal to DPL. A fetch from a conforming one needs `cpl` greater than or equal to DPL. Otherwise it is cause 4. `rpl` plays no part in fetches.
- R10: Causes are 0 none, 1 absent, 2 limit, 3 type, 4 privilege. Priority is 1, then 3, then 4, then 2. `fault` is 1 exactly when the registered cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| seg_base | input | 32 | Segment base from the descriptor cache |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Limit counts 4 KB pages when 1 |
| seg_big | input | 1 | Upper bound 0xFFFFFFFF (1) or 0xFFFF (0) for downward segments |
| seg_rights | input | 8 | Access-rights byte |
| offset | input | 32 | Offset within the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_size | input | 2 | Access byte count minus one |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level of the selector |
| out_valid | output | 1 | Registered request valid |
| lin_addr | output | 32 | Registered linear address |
| fault | output | 1 | Registered fault flag |
| fault_cause | output | 3 | Registered fault cause |

## Verification
Every result of this block is due at the first rising edge after the request is driven: the address, the fault flag and the cause all come from the same output register. The bench drives each request on a falling edge. On the next falling edge, half a cycle after the capturing edge, it compares all four outputs against a behavioural model evaluated at drive time. Directed vectors sit on each limit boundary, each rights combination and each priority pairing. Random vectors that cluster offsets around the effective limit follow them.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      CAUSE_NONE   = 3'd0,
      CAUSE_ABSENT = 3'd1,
      CAUSE_LIMIT  = 3'd2,
      CAUSE_TYPE   = 3'd3,
      CAUSE_PRIV   = 3'd4
   } cause_e;

   // bit positions inside the access-rights byte
   localparam int RB_RW      = 1;
   localparam int RB_DIR     = 2;
   localparam int RB_CODE    = 3;
   localparam int RB_NONSYS  = 4;
   localparam int RB_DPL_LO  = 5;
   localparam int RB_PRESENT = 7;

endpackage

// File: rtl/seg_rights_decode.sv
module seg_rights_decode
   import seg_chk_pkg::*;
#(
   parameter int RIGHTS_W = 8,
   parameter int PL_W     = 2
) (
   input  logic [RIGHTS_W-1:0] rights,
   input  logic [1:0]          kind,
   output logic                present,
   output logic                is_code,
   output logic                conforming,
   output logic                grows_down,
   output logic [PL_W-1:0]     dpl,
   output logic                type_bad
);

   logic is_rd, is_wr, is_fetch, is_rsvd, rw_bit;

   assign is_rd    = (kind == ACC_READ);
   assign is_wr    = (kind == ACC_WRITE);
   assign is_fetch = (kind == ACC_FETCH);
   assign is_rsvd  = (kind == ACC_RSVD);

   assign present    = rights[RB_PRESENT];
   assign is_code    = rights[RB_CODE];
   assign rw_bit     = rights[RB_RW];
   assign conforming = is_code & rights[RB_DIR];
   assign grows_down = ~is_code & rights[RB_DIR];
   assign dpl        = rights[RB_DPL_LO +: PL_W];

   always_comb begin
      if (!rights[RB_NONSYS] || is_rsvd) begin
         type_bad = 1'b1;
      end else if (is_code) begin
         type_bad = is_wr | (is_rd & ~rw_bit);
      end else begin
         type_bad = is_fetch | (is_wr & ~rw_bit);
      end
   end

endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
   import seg_chk_pkg::*;
#(
   parameter int PL_W = 2
) (
   input  logic [PL_W-1:0] cpl,
   input  logic [PL_W-1:0] rpl,
   input  logic [PL_W-1:0] dpl,
   input  logic [1:0]      kind,
   input  logic            conforming,
   output logic            priv_bad
);

   logic [PL_W-1:0] eff_pl;

   // weaker (numerically larger) of the two levels
   assign eff_pl = (cpl > rpl) ? cpl : rpl;

   always_comb begin
      if (kind == ACC_FETCH) begin
         priv_bad = conforming ? (cpl < dpl) : (cpl != dpl);
      end else if (conforming) begin
         priv_bad = 1'b0;
      end else begin
         priv_bad = (eff_pl > dpl);
      end
   end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SMALL_W    = 16,
   parameter int SIZE_W     = 2
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   input  logic              big,
   input  logic              grows_down,
   input  logic [SIZE_W-1:0] size_m1,
   output logic              over_limit
);

   localparam int PAD_B = ADDR_W - LIM_W;
   localparam int PAD_G = ADDR_W - LIM_W - GRAN_SHIFT;
   localparam int PAD_S = ADDR_W - SMALL_W;
   localparam int PAD_Z = ADDR_W + 1 - SIZE_W;

   logic [ADDR_W-1:0] lim_bytes, lim_pages, eff_lim, top_bound;
   logic [ADDR_W:0]   last_byte;
   logic              up_bad, dn_bad;

   assign lim_bytes = {{PAD_B{1'b0}}, limit};

   generate
      if (PAD_G == 0) begin : g_full_pages
         assign lim_pages = {limit, {GRAN_SHIFT{1'b1}}};
      end else begin : g_pad_pages
         assign lim_pages = {{PAD_G{1'b0}}, limit, {GRAN_SHIFT{1'b1}}};
      end
   endgenerate

   assign eff_lim   = gran ? lim_pages : lim_bytes;
   assign top_bound = big ? {ADDR_W{1'b1}} : {{PAD_S{1'b0}}, {SMALL_W{1'b1}}};
   assign last_byte = {1'b0, offset} + {{PAD_Z{1'b0}}, size_m1};

   assign up_bad = (last_byte > {1'b0, eff_lim});
   assign dn_bad = (offset <= eff_lim) || (last_byte > {1'b0, top_bound});

   assign over_limit = grows_down ? dn_bad : up_bad;

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SMALL_W    = 16,
   parameter int SIZE_W     = 2,
   parameter int PL_W       = 2,
   parameter int RIGHTS_W   = 8,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       seg_base,
   input  logic [19:0]       seg_limit,
   input  logic              seg_gran,
   input  logic              seg_big,
   input  logic [7:0]        seg_rights,
   input  logic [31:0]       offset,
   input  logic [1:0]        acc_kind,
   input  logic [1:0]        acc_size,
   input  logic [1:0]        cpl,
   input  logic [1:0]        rpl,
   output logic              out_valid,
   output logic [31:0]       lin_addr,
   output logic              fault,
   output logic [2:0]        fault_cause
);

   localparam int CAUSE_W = $bits(cause_e);

   generate
      if (ADDR_W != 32 || LIM_W != 20 || SIZE_W != 2 || PL_W != 2 || RIGHTS_W != 8) begin : g_port_mismatch
         $error("seg_access_check: port widths are fixed to the default parameter set");
      end
      if (ADDR_W < LIM_W + GRAN_SHIFT) begin : g_gran_overflow
         $error("seg_access_check: scaled limit does not fit the address width");
      end
      if (SMALL_W > ADDR_W) begin : g_small_bound
         $error("seg_access_check: small upper bound wider than the address");
      end
   endgenerate

   logic              present, is_code, conforming, grows_down, type_bad, priv_bad, over_limit;
   logic [PL_W-1:0]   dpl;
   logic [ADDR_W-1:0] addr_c;
   cause_e            cause_c;

   seg_rights_decode #(.RIGHTS_W(RIGHTS_W), .PL_W(PL_W)) u_rights (
      .rights     (seg_rights),
      .kind       (acc_kind),
      .present    (present),
      .is_code    (is_code),
      .conforming (conforming),
      .grows_down (grows_down),
      .dpl        (dpl),
      .type_bad   (type_bad)
   );

   seg_priv_check #(.PL_W(PL_W)) u_priv (
      .cpl        (cpl),
      .rpl        (rpl),
      .dpl        (dpl),
      .kind       (acc_kind),
      .conforming (conforming),
      .priv_bad   (priv_bad)
   );

   seg_limit_check #(
      .ADDR_W     (ADDR_W),
      .LIM_W      (LIM_W),
      .GRAN_SHIFT (GRAN_SHIFT),
      .SMALL_W    (SMALL_W),
      .SIZE_W     (SIZE_W)
   ) u_limit (
      .offset     (offset),
      .limit      (seg_limit),
      .gran       (seg_gran),
      .big        (seg_big),
      .grows_down (grows_down),
      .size_m1    (acc_size),
      .over_limit (over_limit)
   );

   assign addr_c = seg_base + offset;

   // fixed priority: absent, type, privilege, limit
   always_comb begin
      if (!present)        cause_c = CAUSE_ABSENT;
      else if (type_bad)   cause_c = CAUSE_TYPE;
      else if (priv_bad)   cause_c = CAUSE_PRIV;
      else if (over_limit) cause_c = CAUSE_LIMIT;
      else                 cause_c = CAUSE_NONE;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               lin_addr    <= '0;
               fault       <= 1'b0;
               fault_cause <= CAUSE_NONE;
            end else begin
               out_valid   <= req_valid;
               lin_addr    <= addr_c;
               fault       <= req_valid && (cause_c != CAUSE_NONE);
               fault_cause <= req_valid ? CAUSE_W'(cause_c) : CAUSE_W'(CAUSE_NONE);
            end
         end
      end else begin : g_comb_out
         assign out_valid   = req_valid;
         assign lin_addr    = addr_c;
         assign fault       = req_valid && (cause_c != CAUSE_NONE);
         assign fault_cause = req_valid ? CAUSE_W'(cause_c) : CAUSE_W'(CAUSE_NONE);
      end
   endgenerate

endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [31:0] seg_base,
   input logic [7:0]  seg_rights,
   input logic [31:0] offset,
   input logic [1:0]  acc_kind,
   input logic        out_valid,
   input logic [31:0] lin_addr,
   input logic        fault,
   input logic [2:0]  fault_cause
);

   p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(req_valid))
      else $error("out_valid does not trail req_valid by one cycle");

   p_idle_no_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!fault && fault_cause == 3'd0))
      else $error("fault reported without a request");

   p_linear_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> lin_addr == $past(seg_base + offset))
      else $error("linear address differs from base plus offset");

   p_absent_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && !seg_rights[7]) |-> fault_cause == 3'd1)
      else $error("absent segment not reported as cause 1");

   p_code_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && seg_rights[7] && seg_rights[4] && seg_rights[3] && acc_kind == 2'd1)
         |-> fault_cause == 3'd3)
      else $error("write to code segment not a type fault");

   p_fault_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault == (fault_cause != 3'd0))
      else $error("fault flag disagrees with cause");

   p_cause_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cause <= 3'd4)
      else $error("cause outside the defined encodings");

endmodule

bind seg_access_check seg_access_check_sva u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .seg_base    (seg_base),
   .seg_rights  (seg_rights),
   .offset      (offset),
   .acc_kind    (acc_kind),
   .out_valid   (out_valid),
   .lin_addr    (lin_addr),
   .fault       (fault),
   .fault_cause (fault_cause)
);

// File: tb/seg_access_check_test.sv
module seg_access_check_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] seg_base = '0;
   logic [19:0] seg_limit = '0;
   logic        seg_gran = 1'b0;
   logic        seg_big = 1'b0;
   logic [7:0]  seg_rights = '0;
   logic [31:0] offset = '0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  acc_size = '0;
   logic [1:0]  cpl = '0;
   logic [1:0]  rpl = '0;
   logic        out_valid;
   logic [31:0] lin_addr;
   logic        fault;
   logic [2:0]  fault_cause;

   always #5 clk = ~clk;

   seg_access_check uut (.*);

   int    vectors = 0;
   int    miscompares = 0;
   bit    finished = 0;

   bit          e_valid = 0;
   bit          e_fault = 0;
   logic [31:0] e_addr = '0;
   int          e_cause = 0;
   string       e_tag = "R1";

   function automatic void ref_model(
      input logic [31:0] base, input logic [31:0] off, input logic [19:0] lim,
      input bit g, input bit big, input logic [7:0] r, input int kind, input int sz,
      input int cl, input int rl,
      output logic [31:0] addr, output int cause, output string tag);
      longint eff, last, top;
      bit code, down, lim_bad, type_bad, priv_bad;
      int dpl, epl;
      addr = base + off;
      code = r[3];
      down = !code && r[2];
      dpl  = int'(r[6:5]);
      epl  = (cl > rl) ? cl : rl;
      eff  = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
      last = longint'(off) + longint'(sz);
      if (down) begin
         top = big ? 64'h0000_0000_FFFF_FFFF : 64'd65535;
         lim_bad = (longint'(off) <= eff) || (last > top);
      end else begin
         lim_bad = (last > eff);
      end
      type_bad = !r[4] || kind == 3 ||
                 ( code && (kind == 1 || (kind == 0 && !r[1]))) ||
                 (!code && (kind == 2 || (kind == 1 && !r[1])));
      if (kind == 2)            priv_bad = (code && r[2]) ? (cl < dpl) : (cl != dpl);
      else if (code && r[2])    priv_bad = 0;
      else                      priv_bad = (epl > dpl);
      if (!r[7])         begin cause = 1; tag = "R6"; end
      else if (type_bad) begin cause = 3; tag = "R7"; end
      else if (priv_bad) begin cause = 4; tag = (kind == 2) ? "R9" : "R8"; end
      else if (lim_bad)  begin cause = 2; tag = down ? "R5" : (g ? "R3" : "R4"); end
      else               begin cause = 0; tag = "R10"; end
   endfunction

   task automatic report(input string tag, input string what, input longint act, input longint exp);
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
   endtask

   task automatic compare_now();
      vectors++;
      if (out_valid !== e_valid) report("R1", "out_valid", longint'(out_valid), longint'(e_valid));
      else if (e_valid) begin
         if (lin_addr !== e_addr) report("R2", "lin_addr", longint'(lin_addr), longint'(e_addr));
         if (fault_cause !== 3'(e_cause)) report(e_tag, "fault_cause", longint'(fault_cause), longint'(e_cause));
         if (fault !== e_fault) report("R10", "fault", longint'(fault), longint'(e_fault));
      end else if (fault !== 1'b0) report("R1", "idle fault", longint'(fault), 0);
   endtask

   // one request per cycle: check the previous result, then drive the next one
   task automatic apply(input bit v, input logic [31:0] base, input logic [19:0] lim,
                        input bit g, input bit big, input logic [7:0] r,
                        input logic [31:0] off, input int kind, input int sz,
                        input int cl, input int rl);
      logic [31:0] a;
      int c;
      string t;
      @(negedge clk);
      compare_now();
      req_valid  = v;
      seg_base   = base;
      seg_limit  = lim;
      seg_gran   = g;
      seg_big    = big;
      seg_rights = r;
      offset     = off;
      acc_kind   = 2'(kind);
      acc_size   = 2'(sz);
      cpl        = 2'(cl);
      rpl        = 2'(rl);
      ref_model(base, off, lim, g, big, r, kind, sz, cl, rl, a, c, t);
      e_valid = v;
      e_addr  = a;
      e_cause = v ? c : 0;
      e_fault = v && (c != 0);
      e_tag   = t;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // reset state, R1
      repeat (2) begin
         @(negedge clk);
         vectors++;
         if (out_valid !== 1'b0 || fault !== 1'b0 || fault_cause !== 3'd0)
            report("R1", "reset outputs", longint'({out_valid, fault, fault_cause}), 0);
      end
      rst_n = 1'b1;

      // R4 upward limit at the exact boundary
      apply(1, 32'h1000, 20'hFFF, 0, 0, 8'h92, 32'hFFC, 0, 3, 0, 0);
      apply(1, 32'h1000, 20'hFFF, 0, 0, 8'h92, 32'hFFD, 0, 3, 0, 0);
      apply(1, 32'h1000, 20'hFFF, 0, 0, 8'h92, 32'hFFF, 1, 0, 0, 0);
      // R3 granularity scaling
      apply(1, 32'h0, 20'h1, 1, 0, 8'h92, 32'h1FFF, 0, 0, 0, 0);
      apply(1, 32'h0, 20'h1, 1, 0, 8'h92, 32'h2000, 0, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFFF, 1, 0, 8'h92, 32'hFFFF_FFFC, 1, 3, 0, 0);
      // R5 downward segments, small and big upper bound
      apply(1, 32'h8000, 20'hFFF, 0, 0, 8'h96, 32'hFFF, 1, 0, 0, 0);
      apply(1, 32'h8000, 20'hFFF, 0, 0, 8'h96, 32'h1000, 1, 0, 0, 0);
      apply(1, 32'h8000, 20'hFFF, 0, 0, 8'h96, 32'hFFFE, 0, 1, 0, 0);
      apply(1, 32'h8000, 20'hFFF, 0, 0, 8'h96, 32'hFFFE, 0, 3, 0, 0);
      apply(1, 32'h8000, 20'hFFF, 0, 1, 8'h96, 32'hFFFE, 0, 3, 0, 0);
      apply(1, 32'h8000, 20'h1, 1, 1, 8'h96, 32'h1FFF, 0, 0, 0, 0);
      // R6 absent wins over type, privilege and limit
      apply(1, 32'h0, 20'h0, 0, 0, 8'h1A, 32'h100, 1, 3, 3, 3);
      apply(1, 32'h0, 20'h0, 0, 0, 8'h02, 32'h0, 0, 0, 0, 0);
      // R7 type faults
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h9A, 32'h10, 1, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h92, 32'h10, 2, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h90, 32'h10, 1, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h98, 32'h10, 0, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h82, 32'h10, 0, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h92, 32'h10, 3, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h90, 32'h10, 0, 0, 0, 0);
      // R8 data privilege through cpl and rpl
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'h92, 32'h10, 0, 0, 3, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hD2, 32'h10, 1, 0, 0, 3);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hD2, 32'h10, 1, 0, 2, 1);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hBE, 32'h10, 0, 0, 3, 3);
      // R9 fetch rules
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hFA, 32'h10, 2, 0, 3, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hFA, 32'h10, 2, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hBE, 32'h10, 2, 0, 3, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hBE, 32'h10, 2, 0, 0, 0);
      apply(1, 32'h0, 20'hFFFF, 0, 0, 8'hBA, 32'h10, 2, 0, 1, 3);
      // R10 priority between type, privilege and limit
      apply(1, 32'h0, 20'h0, 0, 0, 8'h90, 32'h100, 1, 0, 3, 3);
      apply(1, 32'h0, 20'h0, 0, 0, 8'h92, 32'h100, 1, 0, 3, 3);
      // R2 address wraps modulo 2^32
      apply(1, 32'hFFFF_FF00, 20'hFFFFF, 1, 0, 8'h92, 32'h200, 0, 0, 0, 0);
      // R1 idle cycle between requests
      apply(0, 32'h0, 20'h0, 0, 0, 8'h00, 32'h0, 0, 0, 0, 0);

      // random traffic clustered around the effective limit
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  r;
         logic [19:0] lim;
         logic [31:0] off;
         bit          g;
         longint      eff;
         r = 8'($urandom);
         if ($urandom_range(0, 7) != 0) r[7] = 1'b1;
         if ($urandom_range(0, 7) != 0) r[4] = 1'b1;
         g   = 1'($urandom);
         lim = ($urandom_range(0, 3) == 0) ? 20'($urandom) : 20'($urandom_range(0, 64));
         eff = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
         if ($urandom_range(0, 2) == 0) off = $urandom;
         else off = 32'(eff + longint'($urandom_range(0, 8)) - 4);
         apply($urandom_range(0, 9) != 0, $urandom, lim, g, 1'($urandom), r, off,
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      end
      apply(0, 32'h0, 20'h0, 0, 0, 8'h00, 32'h0, 0, 0, 0, 0);
      @(negedge clk);
      compare_now();

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule